// File: doc/BRIEF.md
# Display Controller Power-Up Sequencer

This block brings an external display controller out of reset and through its setup without a processor. It drives a 16-bit parallel write-only bus in the common 8080 style: chip select, write strobe, a data/command select and the data lines. It also drives the controller's reset line and a backlight enable. When `start` arrives, it pulses the reset line, waits for the controller to settle, and then plays a fixed table of commands from an on-chip ROM. Each command may carry parameters and may be followed by a pause. When the table is finished, the block raises `done` and turns on the backlight.

All waits count a microsecond tick made by a prescaler of `US_CLKS` clocks. A "millisecond" is `MS_US` ticks. A simulation can therefore use short values, while silicon uses the real clock ratio.

Each table entry is stored as a command byte, a parameter count, a post-delay in milliseconds and then the parameter bytes. A count of 0xFF marks the end of the table.

Top module: `lcd_boot_seq`

## Requirements
- R1: While `rst` is high and after it falls, with no start yet: `lcd_cs_n`, `lcd_wr_n` and `lcd_rst_n` are 1, and `busy`, `done` and `backlight` are 0.
- R2: A start pulse drives `lcd_rst_n` low, one cycle later, for RST_US ticks. `lcd_rst_n` then returns high, and no bus write begins for at least another RST_US ticks. `lcd_cs_n` stays high while `lcd_rst_n` is low.
- R3: `lcd_dc` is 0 during the write that carries a command byte and 1 during every parameter write.
- R4: Every write places its byte on `lcd_db[7:0]` with `lcd_db[15:8]` = 0.
- R5: The writes follow this order, in hex, with parameters shown in brackets: E2[1D 02 04]; E0[01], then 1 ms; E0[03], then 5 ms; 01[], then 5 ms; B0[20 00 01 DF 01 0F 00]; B4[02 13 00 2B 0A 00 08 00]; B6[01 20 00 0C 0A 00 01]; F0[03]; 29[]. That makes 37 writes in total. Multi-byte values go most significant byte first (width 479 is sent as 01 then DF).
- R6: In each write, `lcd_cs_n` goes low first and `lcd_wr_n` is low for exactly WR_LOW clocks. `lcd_wr_n` rises while `lcd_cs_n` is still low, and `lcd_db`/`lcd_dc` do not change while `lcd_cs_n` is low.
- R7: After an entry with a delay of D ms, the next chip-select fall comes at least D·MS_US·US_CLKS clocks after the previous chip-select rise, and not more than 16 clocks beyond that. Writes without a delay are at most 16 clocks apart.
- R8: `busy` rises the cycle after an accepted start and stays high until the end. At the end `done` rises and `busy` falls in the same cycle. `done` holds until the next start, and `busy` and `done` are never both high.
- R9: A start pulse while `busy` is high is ignored, and the write stream goes on unchanged.
- R10: `backlight` is 0 during the sequence and goes to 1 together with `done`.
- R11: A table entry whose count byte is 0xFF ends the sequence, and no further writes follow. A start while idle or done runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the power-up sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_dc | output | 1 | 0 = command, 1 = parameter |
| lcd_db | output | 16 | Data bus |
| lcd_rst_n | output | 1 | Controller reset, active low |
| backlight | output | 1 | Backlight enable |

## Verification
The bench replays the sequence twice with random idle gaps and random start pokes while busy. A design that restarts on such a poke would repeat the first writes and break the write order. It measures the reset pulse and the settle time, which catches an off-by-one or a missing prescaler. It measures every strobe width and every gap around the 1 ms and 5 ms pauses; a skipped or shortened pause shows up as a gap that is too small. It also checks that the very first parameter after a command is correct, which is where a design with the wrong ROM read latency sends a stale byte, and that the 0xFF end marker stops the stream at exactly 37 writes.

// File: rtl/lcd_boot_pkg.sv
package lcd_boot_pkg;
  localparam logic [7:0] END_MARK = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_RSTLO, S_SETTLE, S_A_CMD, S_A_CNT, S_A_DLY, S_A_PAR0,
    S_CMD_W, S_PAR_ISSUE, S_PAR_W, S_POST, S_WAIT, S_DONE
  } seq_state_t;

  typedef enum logic [1:0] { W_IDLE, W_SET, W_LOW, W_HOLD } wr_state_t;
endpackage

// File: rtl/lcd_boot_rom.sv
module lcd_boot_rom #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  // Entry: command, count, delay (ms), parameters; count 0xFF ends the table
  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    case (int'(a))
      0: rom_byte = 8'hE2;  1: rom_byte = 8'd3;  2: rom_byte = 8'd0;
      3: rom_byte = 8'h1D;  4: rom_byte = 8'h02; 5: rom_byte = 8'h04;
      6: rom_byte = 8'hE0;  7: rom_byte = 8'd1;  8: rom_byte = 8'd1;
      9: rom_byte = 8'h01;
      10: rom_byte = 8'hE0; 11: rom_byte = 8'd1; 12: rom_byte = 8'd5;
      13: rom_byte = 8'h03;
      14: rom_byte = 8'h01; 15: rom_byte = 8'd0; 16: rom_byte = 8'd5;
      17: rom_byte = 8'hB0; 18: rom_byte = 8'd7; 19: rom_byte = 8'd0;
      20: rom_byte = 8'h20; 21: rom_byte = 8'h00; 22: rom_byte = 8'h01;
      23: rom_byte = 8'hDF; 24: rom_byte = 8'h01; 25: rom_byte = 8'h0F;
      26: rom_byte = 8'h00;
      27: rom_byte = 8'hB4; 28: rom_byte = 8'd8; 29: rom_byte = 8'd0;
      30: rom_byte = 8'h02; 31: rom_byte = 8'h13; 32: rom_byte = 8'h00;
      33: rom_byte = 8'h2B; 34: rom_byte = 8'h0A; 35: rom_byte = 8'h00;
      36: rom_byte = 8'h08; 37: rom_byte = 8'h00;
      38: rom_byte = 8'hB6; 39: rom_byte = 8'd7; 40: rom_byte = 8'd0;
      41: rom_byte = 8'h01; 42: rom_byte = 8'h20; 43: rom_byte = 8'h00;
      44: rom_byte = 8'h0C; 45: rom_byte = 8'h0A; 46: rom_byte = 8'h00;
      47: rom_byte = 8'h01;
      48: rom_byte = 8'hF0; 49: rom_byte = 8'd1; 50: rom_byte = 8'd0;
      51: rom_byte = 8'h03;
      52: rom_byte = 8'h29; 53: rom_byte = 8'd0; 54: rom_byte = 8'd0;
      55: rom_byte = 8'h00; 56: rom_byte = 8'hFF;
      default: rom_byte = 8'hFF;
    endcase
  endfunction

  always_ff @(posedge clk) q <= rom_byte(addr);
endmodule

// File: rtl/lcd_us_timer.sv
module lcd_us_timer #(
  parameter int US_CLKS = 50,
  parameter int TW      = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_us,
  output logic          expired
);
  localparam int PW = $clog2(US_CLKS) + 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(US_CLKS - 1);

  logic [PW-1:0] pre;
  logic [TW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      remain <= '0;
    end else if (load) begin
      pre    <= '0;
      remain <= load_us;
    end else if (remain != '0) begin
      if (pre == PRE_LAST) begin
        pre    <= '0;
        remain <= remain - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
  import lcd_boot_pkg::*;
#(
  parameter int WR_LOW = 2,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_dc,
  input  logic [DW-1:0] req_data,
  output logic          wdone,
  output logic          cs_n,
  output logic          wr_n,
  output logic          dc,
  output logic [DW-1:0] db
);
  localparam int CW = $clog2(WR_LOW) + 1;
  localparam logic [CW-1:0] LOW_LAST = CW'(WR_LOW - 1);

  wr_state_t     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= W_IDLE;
      cnt   <= '0;
      wdone <= 1'b0;
      cs_n  <= 1'b1;
      wr_n  <= 1'b1;
      dc    <= 1'b1;
      db    <= '0;
    end else begin
      wdone <= 1'b0;
      case (st)
        W_IDLE: if (req) begin
          cs_n <= 1'b0;
          dc   <= req_dc;
          db   <= req_data;
          st   <= W_SET;
        end
        W_SET: begin
          wr_n <= 1'b0;
          cnt  <= '0;
          st   <= W_LOW;
        end
        W_LOW: begin
          if (cnt == LOW_LAST) begin
            wr_n <= 1'b1;
            st   <= W_HOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cs_n  <= 1'b1;
          wdone <= 1'b1;
          st    <= W_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
  import lcd_boot_pkg::*;
#(
  parameter int US_CLKS = 50,
  parameter int MS_US   = 1000,
  parameter int RST_US  = 100,
  parameter int WR_LOW  = 2,
  parameter int ROM_AW  = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        lcd_cs_n,
  output logic        lcd_wr_n,
  output logic        lcd_dc,
  output logic [15:0] lcd_db,
  output logic        lcd_rst_n,
  output logic        backlight
);
  localparam int TW = $clog2(255 * MS_US + RST_US + 1) + 1;
  localparam logic [TW-1:0] MS_W  = TW'(MS_US);
  localparam logic [TW-1:0] RST_W = TW'(RST_US);

  seq_state_t        st;
  logic [ROM_AW-1:0] ptr;
  logic [7:0]        rom_q, cmd, cnt, dly;
  logic              t_load, t_exp;
  logic [TW-1:0]     t_val;
  logic              w_req, w_dc, w_done;
  logic [15:0]       w_data;

  lcd_boot_rom #(.AW(ROM_AW)) u_rom (.clk(clk), .addr(ptr), .q(rom_q));

  lcd_us_timer #(.US_CLKS(US_CLKS), .TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_us(t_val), .expired(t_exp));

  lcd_bus_writer #(.WR_LOW(WR_LOW), .DW(16)) u_wr (
    .clk(clk), .rst(rst), .req(w_req), .req_dc(w_dc), .req_data(w_data),
    .wdone(w_done), .cs_n(lcd_cs_n), .wr_n(lcd_wr_n), .dc(lcd_dc), .db(lcd_db));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ptr       <= '0;
      cmd       <= '0;
      cnt       <= '0;
      dly       <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      lcd_rst_n <= 1'b1;
      backlight <= 1'b0;
      t_load    <= 1'b0;
      t_val     <= '0;
      w_req     <= 1'b0;
      w_dc      <= 1'b1;
      w_data    <= '0;
    end else begin
      t_load <= 1'b0;
      w_req  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy      <= 1'b1;
          done      <= 1'b0;
          backlight <= 1'b0;
          lcd_rst_n <= 1'b0;
          t_load    <= 1'b1;
          t_val     <= RST_W;
          st        <= S_RSTLO;
        end
        S_RSTLO: if (!t_load && t_exp) begin
          lcd_rst_n <= 1'b1;
          t_load    <= 1'b1;
          t_val     <= RST_W;
          st        <= S_SETTLE;
        end
        S_SETTLE: if (!t_load && t_exp) begin
          ptr <= '0;
          st  <= S_A_CMD;
        end
        S_A_CMD: begin
          ptr <= ptr + 1'b1;
          st  <= S_A_CNT;
        end
        S_A_CNT: begin
          cmd <= rom_q;
          ptr <= ptr + 1'b1;
          st  <= S_A_DLY;
        end
        S_A_DLY: begin
          cnt <= rom_q;
          if (rom_q == END_MARK) begin
            st <= S_DONE;
          end else begin
            ptr <= ptr + 1'b1;
            st  <= S_A_PAR0;
          end
        end
        S_A_PAR0: begin
          dly    <= rom_q;
          w_req  <= 1'b1;
          w_dc   <= 1'b0;
          w_data <= {8'h00, cmd};
          st     <= S_CMD_W;
        end
        S_CMD_W, S_PAR_W: if (w_done) begin
          st <= (cnt == 8'd0) ? S_POST : S_PAR_ISSUE;
        end
        S_PAR_ISSUE: begin
          w_req  <= 1'b1;
          w_dc   <= 1'b1;
          w_data <= {8'h00, rom_q};
          ptr    <= ptr + 1'b1;
          cnt    <= cnt - 1'b1;
          st     <= S_PAR_W;
        end
        S_POST: begin
          if (dly != 8'd0) begin
            t_load <= 1'b1;
            t_val  <= TW'(dly) * MS_W;
            st     <= S_WAIT;
          end else begin
            st <= S_A_CMD;
          end
        end
        S_WAIT: if (!t_load && t_exp) st <= S_A_CMD;
        default: begin
          busy      <= 1'b0;
          done      <= 1'b1;
          backlight <= 1'b1;
          st        <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_boot_seq_chk.sv
module lcd_boot_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        lcd_cs_n,
  input logic        lcd_wr_n,
  input logic        lcd_dc,
  input logic [15:0] lcd_db,
  input logic        lcd_rst_n,
  input logic        backlight
);
  p_strobe_in_select_r6: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> !lcd_cs_n);

  p_bus_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_db) && $stable(lcd_dc)));

  p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> lcd_cs_n);

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_light_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> backlight);

  p_high_byte_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !lcd_cs_n |-> (lcd_db[15:8] == 8'h00));
endmodule

bind lcd_boot_seq lcd_boot_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .lcd_cs_n(lcd_cs_n),
  .lcd_wr_n(lcd_wr_n), .lcd_dc(lcd_dc), .lcd_db(lcd_db),
  .lcd_rst_n(lcd_rst_n), .backlight(backlight));

// File: tb/sim_lcd_boot_seq.sv
`timescale 1ns/1ps
module sim_lcd_boot_seq;
  localparam int U   = 2;
  localparam int MSU = 1000;
  localparam int RU  = 100;
  localparam int WL  = 3;
  localparam int SLACK = 16;

  logic clk = 0, rst = 1, start = 0;
  logic busy, done, cs_n, wr_n, dc, rst_n, bl;
  logic [15:0] db;

  lcd_boot_seq #(.US_CLKS(U), .MS_US(MSU), .RST_US(RU), .WR_LOW(WL)) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .lcd_cs_n(cs_n), .lcd_wr_n(wr_n), .lcd_dc(dc), .lcd_db(db),
    .lcd_rst_n(rst_n), .backlight(bl));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Expected write stream
  logic        e_dc [64];
  logic [15:0] e_db [64];
  int          e_gap[64];
  int          n_exp = 0, pend_gap = RU * U;

  task automatic add(input logic [7:0] c, input int n, input int dms, input logic [63:0] pk);
    e_dc[n_exp] = 0; e_db[n_exp] = {8'h00, c}; e_gap[n_exp] = pend_gap; n_exp++;
    for (int i = 0; i < n; i++) begin
      e_dc[n_exp] = 1; e_db[n_exp] = {8'h00, pk[63-8*i -: 8]}; e_gap[n_exp] = 0; n_exp++;
    end
    pend_gap = dms * MSU * U;
  endtask

  // Monitor
  int  k = 0, t_rfall = 0, t_rrise = 0, t_csrise = 0, t_wfall = 0;
  bit  first_w = 0, mon_on = 0;
  logic p_cs = 1, p_wr = 1, p_rn = 1;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_rn && !rst_n) t_rfall = cyc;
      if (!p_rn && rst_n) begin
        chk((cyc - t_rfall >= RU*U) && (cyc - t_rfall <= RU*U + 4), "R2 reset width",
            cyc - t_rfall, RU*U);
        t_rrise = cyc; first_w = 1;
      end
      if (p_cs && !cs_n) begin
        int gap, gmin;
        gap  = first_w ? (cyc - t_rrise) : (cyc - t_csrise);
        gmin = (k < 64) ? e_gap[k] : 0;
        chk(gap >= gmin && gap <= gmin + SLACK, first_w ? "R2 settle" : "R7 gap",
            gap, gmin);
        first_w = 0;
      end
      if (p_wr && !wr_n) t_wfall = cyc;
      if (!p_wr && wr_n) begin
        chk(cyc - t_wfall == WL, "R6 strobe width", cyc - t_wfall, WL);
        chk(!cs_n, "R6 cs held at strobe rise", cs_n, 0);
        if (k < n_exp) begin
          chk(dc == e_dc[k], e_dc[k] ? "R3 dc param" : "R3 dc cmd", dc, e_dc[k]);
          chk(db == e_db[k], "R5/R4 data", db, e_db[k]);
        end else begin
          chk(0, "R11 extra write", k, n_exp);
        end
        k++;
      end
      if (!p_cs && cs_n) t_csrise = cyc;
    end
    p_cs = cs_n; p_wr = wr_n; p_rn = rst_n;
  end

  task automatic run_seq(input int idle, input bit poke);
    repeat (idle) @(negedge clk);
    k = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R8 busy after start", busy, 1);
    chk(done == 0, "R8 done cleared", done, 0);
    chk(rst_n == 0, "R2 reset driven", rst_n, 0);
    chk(bl == 0, "R10 backlight off", bl, 0);
    while (!done) begin
      @(negedge clk);
      if (poke && busy && !done) start = (($urandom % 53) == 0);
      else start = 0;
      if (!done) chk(busy == 1, "R8 busy held", busy, 1);
    end
    start = 0;
    chk(busy == 0, "R8 busy low at end", busy, 0);
    chk(bl == 1, "R10 backlight on", bl, 1);
    chk(k == n_exp, "R11 write count", k, n_exp);
    repeat (40) @(negedge clk);
    chk(done == 1 && busy == 0, "R8 done holds", done, 1);
    chk(k == n_exp, "R11 no writes after end", k, n_exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    add(8'hE2, 3, 0, 64'h1D0204_0000000000);
    add(8'hE0, 1, 1, 64'h01_00000000000000);
    add(8'hE0, 1, 5, 64'h03_00000000000000);
    add(8'h01, 0, 5, 64'h0);
    add(8'hB0, 7, 0, 64'h200001DF010F00_00);
    add(8'hB4, 8, 0, 64'h0213002B0A000800);
    add(8'hB6, 7, 0, 64'h0120000C0A0001_00);
    add(8'hF0, 1, 0, 64'h03_00000000000000);
    add(8'h29, 0, 0, 64'h0);
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && rst_n && !busy && !done && !bl, "R1 in reset",
        {cs_n, wr_n, rst_n, busy, done, bl}, 6'b111000);
    rst = 0;
    mon_on = 1;
    repeat (5) @(negedge clk);
    chk(cs_n && wr_n && rst_n && !busy && !done && !bl, "R1 after reset",
        {cs_n, wr_n, rst_n, busy, done, bl}, 6'b111000);
    run_seq(1 + int'($urandom % 30), 1'b1);   // R9 pokes while busy
    run_seq(1 + int'($urandom % 30), 1'b0);   // R11 rerun from done
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule